// File: doc/BRIEF.md
# Set/Clear Aliased Register Bank

This block is a bank of peripheral control registers. Software reaches it through a simple synchronous slave port with a word address, write data, a write strobe, a read strobe and a read data bus. Every register's contents are also driven out in parallel to the logic that the registers control.

Part of the bank is made of aliased registers. Each aliased register answers at three word addresses:
- the set alias ORs the write data into the register;
- the clear alias removes every bit that is one in the write data;
- the view alias returns the stored value.

A single bit can therefore be changed with one store and no read-modify-write. Hardware may also raise bits of an aliased register through a per-bit set input. The rest of the bank is made of ordinary read-write registers.

Address map, in word addresses, with `NUM_ALIAS` aliased registers and `NUM_PLAIN` plain registers:
- Aliased register n has its set alias at 4n, its clear alias at 4n+1 and its view alias at 4n+2. Address 4n+3 is a hole.
- Plain register m sits at 4·`NUM_ALIAS` + m.
- Every other address is unmapped.

Read data is registered: it appears one cycle after the read strobe and is zero in any cycle that follows a cycle without a read.

The address decoder classifies each access as one of five kinds: NONE, SET, CLEAR, VIEW or PLAIN. The read path steps through two conditions: after a cycle with no read, the bus shows zero; after a cycle with a read, it shows the selected value.

Top module: `scbank_top`

## Requirements
- R1: A write to the set alias (word address 4n) makes every bit of aliased register n that is one in the write data a one. Register bits whose write-data bit is zero are left unchanged.
- R2: A write to the clear alias (word address 4n+1) makes every bit of aliased register n that is one in the write data a zero. Register bits whose write-data bit is zero are left unchanged.
- R3: A read of the view alias (word address 4n+2) returns the value of aliased register n as it stood at the read's clock edge. The value appears on rd_data in the following cycle.
- R4: A read of a set alias or a clear alias returns zero.
- R5: A write to a view alias changes no register.
- R6: A bit raised on hw_set is one in the register after that clock edge, even when the same cycle's software write clears that bit.
- R7: While rst_n is low at a clock edge, all registers and rd_data become zero. The reset is synchronous and active low.
- R8: An access to an unmapped address reads as zero and writes nothing. Unmapped addresses are 4n+3, and any address at or above 4·NUM_ALIAS+NUM_PLAIN.
- R9: A write to plain register m (word address 4·NUM_ALIAS+m) replaces its whole value, and a read of that address returns the stored value.
- R10: In a cycle that follows a cycle with rd_en low, rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| hw_set | input | NUM_ALIAS*DATA_W | Per-bit hardware set for the aliased registers; register n uses slice n |
| rd_data | output | DATA_W | Registered read data |
| alias_q | output | NUM_ALIAS*DATA_W | Aliased register contents; register n is in slice n |
| plain_q | output | NUM_PLAIN*DATA_W | Plain register contents; register m is in slice m |

## Verification
The hardest case to reach from the ports is a hardware set that lands on a bit in the very cycle a software clear of that bit is written. A related hard case is a reset that arrives in the middle of write traffic.

The stimulus drives sparse single-bit hw_set pulses at random alongside random set, clear, view, plain and unmapped accesses, so the two sources collide from time to time. A directed step also forces the collision on a known bit. A reset is applied while writes are still being driven, and the bench checks that every output returns to zero.

// File: rtl/scbank_pkg.sv
package scbank_pkg;

    // Kind of access selected by the word address
    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_SET   = 3'd1,
        ACC_CLEAR = 3'd2,
        ACC_VIEW  = 3'd3,
        ACC_PLAIN = 3'd4
    } acc_kind_e;

    // Word stride of one aliased register in the map
    localparam int ALIAS_STRIDE = 4;

endpackage

// File: rtl/scbank_decode.sv
module scbank_decode
    import scbank_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_ALIAS = 4,
    parameter int NUM_PLAIN = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output acc_kind_e            kind,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_ALIAS-1:0] set_sel,
    output logic [NUM_ALIAS-1:0] clr_sel,
    output logic [NUM_PLAIN-1:0] pwr_sel
);

    localparam int PLAIN_BASE = ALIAS_STRIDE * NUM_ALIAS;
    localparam int MAP_END    = PLAIN_BASE + NUM_PLAIN;

    // Classify the address into an access kind and a register index
    always_comb begin
        int a;
        a    = int'(addr);
        kind = ACC_NONE;
        idx  = '0;
        if (a < PLAIN_BASE) begin
            idx = IDX_W'(a / ALIAS_STRIDE);
            unique case (addr[1:0])
                2'd0:    kind = ACC_SET;
                2'd1:    kind = ACC_CLEAR;
                2'd2:    kind = ACC_VIEW;
                default: kind = ACC_NONE;
            endcase
        end else if (a < MAP_END) begin
            kind = ACC_PLAIN;
            idx  = IDX_W'(a - PLAIN_BASE);
        end
    end

    // One write select per register, qualified by the write strobe
    for (genvar i = 0; i < NUM_ALIAS; i++) begin : g_asel
        assign set_sel[i] = wr_en && (kind == ACC_SET)   && (idx == IDX_W'(i));
        assign clr_sel[i] = wr_en && (kind == ACC_CLEAR) && (idx == IDX_W'(i));
    end
    for (genvar j = 0; j < NUM_PLAIN; j++) begin : g_psel
        assign pwr_sel[j] = wr_en && (kind == ACC_PLAIN) && (idx == IDX_W'(j));
    end

    // R8: at most one register is written per cycle, and none for an unmapped address
    p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_sel, clr_sel, pwr_sel}));
    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= MAP_END) |-> ({set_sel, clr_sel, pwr_sel} == '0));
    // R5: a write to a view alias selects no register
    p_view_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_VIEW) |-> ({set_sel, clr_sel, pwr_sel} == '0));

endmodule

// File: rtl/scbank_alias_reg.sv
module scbank_alias_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_sel,
    input  logic              clr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] nxt;

    // Software set, then software clear, then hardware set (hardware wins)
    always_comb begin
        nxt = q;
        if (set_sel) nxt = nxt | wdata;
        if (clr_sel) nxt = nxt & ~wdata;
        nxt = nxt | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_set_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_sel |=> ((q & $past(wdata)) == $past(wdata)));
    p_clear_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sel |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));
    p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_sel && !clr_sel && hw_set == '0) |=> $stable(q));

endmodule

// File: rtl/scbank_plain_reg.sv
module scbank_plain_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_sel) q <= wdata;
    end

    p_plain_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (q == $past(wdata)));
    p_plain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(q));

endmodule

// File: rtl/scbank_rdmux.sv
module scbank_rdmux
    import scbank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_ALIAS = 4,
    parameter int NUM_PLAIN = 4,
    parameter int IDX_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  acc_kind_e                     kind,
    input  logic [IDX_W-1:0]              idx,
    input  logic [NUM_ALIAS*DATA_W-1:0]   alias_flat,
    input  logic [NUM_PLAIN*DATA_W-1:0]   plain_flat,
    output logic [DATA_W-1:0]             rd_data
);

    logic [DATA_W-1:0] alias_pick;
    logic [DATA_W-1:0] plain_pick;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        alias_pick = '0;
        for (int i = 0; i < NUM_ALIAS; i++)
            if (idx == IDX_W'(i)) alias_pick = alias_flat[i*DATA_W +: DATA_W];
    end

    always_comb begin
        plain_pick = '0;
        for (int j = 0; j < NUM_PLAIN; j++)
            if (idx == IDX_W'(j)) plain_pick = plain_flat[j*DATA_W +: DATA_W];
    end

    // Only view aliases and plain registers return data
    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            unique case (kind)
                ACC_VIEW:  rd_next = alias_pick;
                ACC_PLAIN: rd_next = plain_pick;
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
    p_alias_port_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (kind == ACC_SET || kind == ACC_CLEAR)) |=> (rd_data == '0));
    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_NONE) |=> (rd_data == '0));

endmodule

// File: rtl/scbank_top.sv
module scbank_top
    import scbank_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int NUM_ALIAS = 4,
    parameter int NUM_PLAIN = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_ALIAS*DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_ALIAS*DATA_W-1:0] alias_q,
    output logic [NUM_PLAIN*DATA_W-1:0] plain_q
);

    localparam int MAX_N = (NUM_ALIAS > NUM_PLAIN) ? NUM_ALIAS : NUM_PLAIN;
    localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    acc_kind_e            kind;
    logic [IDX_W-1:0]     idx;
    logic [NUM_ALIAS-1:0] set_sel;
    logic [NUM_ALIAS-1:0] clr_sel;
    logic [NUM_PLAIN-1:0] pwr_sel;

    scbank_decode #(
        .ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS), .NUM_PLAIN(NUM_PLAIN), .IDX_W(IDX_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .kind(kind), .idx(idx), .set_sel(set_sel), .clr_sel(clr_sel), .pwr_sel(pwr_sel)
    );

    for (genvar i = 0; i < NUM_ALIAS; i++) begin : g_alias
        scbank_alias_reg #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .set_sel(set_sel[i]), .clr_sel(clr_sel[i]),
            .wdata(wdata), .hw_set(hw_set[i*DATA_W +: DATA_W]),
            .q(alias_q[i*DATA_W +: DATA_W])
        );
    end

    for (genvar j = 0; j < NUM_PLAIN; j++) begin : g_plain
        scbank_plain_reg #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .wr_sel(pwr_sel[j]), .wdata(wdata),
            .q(plain_q[j*DATA_W +: DATA_W])
        );
    end

    scbank_rdmux #(
        .DATA_W(DATA_W), .NUM_ALIAS(NUM_ALIAS), .NUM_PLAIN(NUM_PLAIN), .IDX_W(IDX_W)
    ) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .kind(kind), .idx(idx),
        .alias_flat(alias_q), .plain_flat(plain_q), .rd_data(rd_data)
    );

    // R7: the edge after a low rst_n leaves every register cleared
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= !rst_n;

    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            a_reset_clear_r7: assert (alias_q == '0 && plain_q == '0 && rd_data == '0);
        end
    end

endmodule

// File: tb/scbank_top_tb.sv
module scbank_top_tb;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NA = 4;
    localparam int NP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [NA*DW-1:0] hw_set = '0;
    logic [DW-1:0]    rd_data;
    logic [NA*DW-1:0] alias_q;
    logic [NP*DW-1:0] plain_q;

    always #4 clk = ~clk;

    scbank_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_ALIAS(NA), .NUM_PLAIN(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .hw_set(hw_set), .rd_data(rd_data),
        .alias_q(alias_q), .plain_q(plain_q)
    );

    int total = 0;
    int bad = 0;
    logic [DW-1:0] m_alias [NA];
    logic [DW-1:0] m_plain [NP];
    logic [DW-1:0] exp_rd = '0;
    string         exp_tag = "R10";

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Map kinds: 0 none, 1 set, 2 clear, 3 view, 4 plain
    function automatic int kind_of(int a);
        if (a < 4*NA) begin
            case (a % 4)
                0: return 1;
                1: return 2;
                2: return 3;
                default: return 0;
            endcase
        end
        if (a < 4*NA + NP) return 4;
        return 0;
    endfunction

    function automatic string read_tag(int a);
        case (kind_of(a))
            1, 2: return "R4";
            3:    return "R3";
            4:    return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic compare_all();
        check(exp_tag, rd_data, exp_rd);
        for (int i = 0; i < NA; i++)
            check("R1/R2/R5/R6 alias", alias_q[i*DW +: DW], m_alias[i]);
        for (int j = 0; j < NP; j++)
            check("R9 plain", plain_q[j*DW +: DW], m_plain[j]);
    endtask

    task automatic step(bit w, bit r, int a, logic [DW-1:0] d, logic [NA*DW-1:0] hw);
        int k;
        @(negedge clk);
        compare_all();
        wr_en = w; rd_en = r; addr = AW'(a); wdata = d; hw_set = hw;
        k = kind_of(a);
        if (r) begin
            exp_tag = read_tag(a);
            if (k == 3)      exp_rd = m_alias[a/4];
            else if (k == 4) exp_rd = m_plain[a - 4*NA];
            else             exp_rd = '0;
        end else begin
            exp_tag = "R10";
            exp_rd  = '0;
        end
        if (w) begin
            if (k == 1)      m_alias[a/4] = m_alias[a/4] | d;
            else if (k == 2) m_alias[a/4] = m_alias[a/4] & ~d;
            else if (k == 4) m_plain[a - 4*NA] = d;
        end
        for (int i = 0; i < NA; i++) m_alias[i] = m_alias[i] | hw[i*DW +: DW];
    endtask

    task automatic reset_check();
        for (int i = 0; i < NA; i++) m_alias[i] = '0;
        for (int j = 0; j < NP; j++) m_plain[j] = '0;
        exp_rd = '0; exp_tag = "R7";
        check("R7 rd_data", rd_data, '0);
        check("R7 alias_q", alias_q[DW-1:0], '0);
        check("R7 alias_q all", (alias_q == '0) ? 32'd0 : 32'd1, 32'd0);
        check("R7 plain_q all", (plain_q == '0) ? 32'd0 : 32'd1, 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_check();

        // R1: set alias ORs ones, zero bits keep their value
        step(1, 0, 0, 32'h0000_00F0, '0);
        step(1, 0, 0, 32'h0000_000F, '0);
        step(1, 0, 0, 32'h0, '0);
        step(0, 1, 2, 32'h0, '0);              // R3 view alias: expect 0xFF
        // R2: clear alias removes ones only
        step(1, 0, 1, 32'h0000_000C, '0);
        step(1, 0, 1, 32'h0, '0);
        step(0, 1, 2, 32'h0, '0);              // R3: expect 0xF3
        // R5: write to view alias is ignored
        step(1, 0, 2, 32'hFFFF_FFFF, '0);
        step(0, 1, 2, 32'h0, '0);
        // R4: set and clear aliases read zero
        step(0, 1, 0, 32'h0, '0);
        step(0, 1, 1, 32'h0, '0);
        // R6: hardware set wins over a clear of the same bit
        step(1, 0, 5, 32'hFFFF_FFFF, '0);
        step(1, 0, 4, 32'h0000_0010, '0);
        step(1, 0, 5, 32'h0000_0010, {NA*DW{1'b0}} | (128'h1 << (DW + 4)));
        step(0, 1, 6, 32'h0, '0);              // expect bit 4 set
        // R8: unmapped hole and above-map addresses
        step(1, 0, 3, 32'hDEAD_BEEF, '0);
        step(1, 0, 40, 32'hDEAD_BEEF, '0);
        step(0, 1, 3, 32'h0, '0);
        step(0, 1, 40, 32'h0, '0);
        // R9: plain register write then read
        step(1, 0, 4*NA, 32'h1234_5678, '0);
        step(1, 0, 4*NA + 3, 32'hA5A5_0000, '0);
        step(0, 1, 4*NA, 32'h0, '0);
        step(0, 1, 4*NA + 3, 32'h0, '0);
        step(0, 0, 0, 32'h0, '0);              // R10: idle read bus

        // Constrained random traffic with sparse hardware sets
        for (int n = 0; n < 600; n++) begin
            int op;
            int a;
            logic [NA*DW-1:0] hw;
            op = int'($urandom % 3);
            a  = int'($urandom % 40);
            hw = '0;
            if (($urandom % 4) == 0)
                hw = (128'h1 << ($urandom % (NA*DW)));
            step(op == 0, op == 1, a, $urandom, hw);
        end

        // R6: collision where the clear targets the bit hardware raises
        step(1, 0, 0, 32'h0000_0100, '0);
        step(1, 0, 1, 32'h0000_0100, 128'h100);
        step(0, 1, 2, 32'h0, '0);

        // R7: reset in the middle of write traffic
        @(negedge clk);
        compare_all();
        rst_n = 1'b0;
        wr_en = 1'b1; rd_en = 1'b1; addr = AW'(0); wdata = 32'hFFFF_FFFF; hw_set = '1;
        @(negedge clk);
        addr = AW'(4*NA);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; hw_set = '0;
        rst_n = 1'b1;
        reset_check();
        step(0, 1, 2, 32'h0, '0);
        step(0, 0, 0, 32'h0, '0);
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule